// File: doc/BRIEF.md
# Vectored Interrupt Controller with Return-Stack Gating

This block sits beside a small processor core and handles three interrupt sources: a USB event, a timer 0 overflow and a timer 1 overflow. Each source raises a one-cycle request pulse. The pulse sets a sticky flag in an 8-bit control/status register. The same register holds a global enable and one enable per source, and software reads and writes it through a simple register port.

Once per instruction cycle the core raises a sample strobe. On that strobe, all pending flags whose sources are enabled compete under a fixed priority. The winner is acknowledged in the same cycle, together with a program-memory vector. The acknowledge clears the winner's flag and the global enable, so service routines do not nest unless software allows it. A return-from-interrupt pulse sets the global enable again. An ordinary subroutine return is never signalled to the block, so it leaves the enable unchanged.

Acknowledge is withheld while the core reports that its return stack is full. The flag stays set, and the request is serviced at the first sample after a pop frees a stack level. While the core is halted, a wake output reports any flag that was raised after halt was entered.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The register reads as {bit7 = 0, bit6 = timer 1 flag, bit5 = timer 0 flag, bit4 = USB flag, bit3 = timer 1 enable, bit2 = timer 0 enable, bit1 = USB enable, bit0 = global enable}. A write stores bits 6..0 at the next edge. Reset clears all bits.
- R2: A request pulse sets its flag at the next edge. A flag stays set until it is acknowledged or software writes 0 to it. A request in the same cycle as a software clear of that flag leaves the flag set.
- R3: Acknowledge is high only in a cycle where the sample strobe is high, the global enable is 1, the stack-full input is low and at least one flag has its enable set. A flag whose enable is 0 is never acknowledged.
- R4: When several enabled flags are pending, USB wins over timer 0, and timer 0 wins over timer 1. The vector is 0x004 for USB, 0x008 for timer 0 and 0x00C for timer 1, and it is valid while acknowledge is high.
- R5: At the edge that ends an acknowledge cycle, the serviced flag and the global enable clear. Other flags are kept. This takes precedence over a register write in the same cycle.
- R6: While stack-full is high, an enabled pending request is not acknowledged and its flag is kept. The request is acknowledged at the first sample after stack-full falls.
- R7: A return-from-interrupt pulse sets the global enable at the next edge. It takes precedence over a write in the same cycle but not over an acknowledge.
- R8: If software sets the global enable inside a service routine, a further pending request is acknowledged at the next sample.
- R9: While the halted input is high, wake is high exactly when some flag is set that was not already set in the cycle halt was entered. Enables do not affect wake. Wake is low whenever halted is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Instruction-cycle sample strobe |
| req_usb | input | 1 | USB event request pulse |
| req_tmr0 | input | 1 | Timer 0 overflow request pulse |
| req_tmr1 | input | 1 | Timer 1 overflow request pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| reti | input | 1 | Return-from-interrupt pulse |
| stack_full | input | 1 | Core return stack has no free level |
| ack | output | 1 | Interrupt acknowledge |
| ack_vec | output | VEC_W | Service routine vector |
| halted | input | 1 | Core is in halt |
| wake | output | 1 | Wake-up request to the core |

## Verification
The assertions assume that request, strobe and control inputs are synchronous and stable around the rising edge. They also assume that the core changes stack-full only between samples and never returns while acknowledge is high. The bench drives every input 1 ns after a rising edge, so each value is held for a whole cycle. It issues return pulses only in cycles without a sample strobe, and it raises halted only from an idle state. Within those limits it still places requests, writes and acknowledges in the same cycle, to exercise the precedence rules.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int VEC_W    = 12,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             req_usb,
  input  logic             req_tmr0,
  input  logic             req_tmr1,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             reti,
  input  logic             stack_full,
  output logic             ack,
  output logic [VEC_W-1:0] ack_vec,
  input  logic             halted,
  output logic             wake
);
  localparam int NSRC = 3;

  logic            gie_q, gie_n;
  logic [NSRC-1:0] en_q, en_n, flag_q, flag_n, blk_q;
  logic            halt_d;
  logic [NSRC-1:0] req, pend, grant;
  int              idx;

  assign req  = {req_tmr1, req_tmr0, req_usb};
  assign pend = flag_q & en_q;

  always_comb begin
    grant = '0;
    idx   = 0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        grant = NSRC'(1) << i;
        idx   = i;
      end
    end
  end

  assign ack       = sample_en & gie_q & ~stack_full & (|pend);
  assign ack_vec   = VEC_W'(VEC_BASE + idx * VEC_STEP);
  assign reg_rdata = {1'b0, flag_q, en_q, gie_q};
  assign wake      = halted & (|(flag_q & ~(halt_d ? blk_q : flag_q)));

  always_comb begin
    gie_n  = gie_q;
    en_n   = en_q;
    flag_n = flag_q;
    if (reg_wr) begin
      gie_n  = reg_wdata[0];
      en_n   = reg_wdata[3:1];
      flag_n = reg_wdata[6:4];
    end
    if (reti) gie_n = 1'b1;
    if (ack) begin
      gie_n  = 1'b0;
      flag_n = flag_n & ~grant;
    end
    flag_n = flag_n | req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      en_q   <= '0;
      flag_q <= '0;
      blk_q  <= '0;
      halt_d <= 1'b0;
    end else begin
      gie_q  <= gie_n;
      en_q   <= en_n;
      flag_q <= flag_n;
      halt_d <= halted;
      if (halted && !halt_d) blk_q <= flag_q;
    end
  end
endmodule

module irq_vector_ctrl_chk #(
  parameter int VEC_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_en,
  input logic             stack_full,
  input logic             reti,
  input logic             reg_wr,
  input logic [7:0]       reg_wdata,
  input logic [7:0]       reg_rdata,
  input logic             ack,
  input logic [VEC_W-1:0] ack_vec,
  input logic             halted,
  input logic             wake
);
  // R3 R6
  ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (sample_en && !stack_full && reg_rdata[0]));

  // R5
  ack_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !reg_rdata[0]);

  // R7
  reti_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack) |=> reg_rdata[0]);

  // R4
  usb_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && reg_rdata[4] && reg_rdata[1]) |-> (ack_vec == VEC_W'(4)));

  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[4] && !ack && !(reg_wr && !reg_wdata[4])) |=> reg_rdata[4]);

  // R9
  wake_only_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |-> !wake);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .stack_full(stack_full),
  .reti(reti), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .ack(ack), .ack_vec(ack_vec), .halted(halted), .wake(wake)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_en = 1'b0, req_usb = 1'b0, req_tmr0 = 1'b0, req_tmr1 = 1'b0;
  logic        reg_wr = 1'b0, reti = 1'b0, stack_full = 1'b0, halted = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        ack, wake;
  logic [11:0] ack_vec;

  always #10 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .req_usb(req_usb),
    .req_tmr0(req_tmr0), .req_tmr1(req_tmr1), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reti(reti),
    .stack_full(stack_full), .ack(ack), .ack_vec(ack_vec),
    .halted(halted), .wake(wake)
  );

  typedef struct {
    string       tag;
    logic [7:0]  rd;
    logic        a;
    logic [11:0] v;
    logic        w;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  logic [6:0] m   = '0;
  logic [2:0] mb  = '0;
  logic       mhd = 1'b0;

  task automatic cyc(input logic s, input logic [2:0] rq, input logic wr,
                     input logic [7:0] wd, input logic rt, input logic full,
                     input logic hl, input string tag);
    exp_t       e;
    logic [2:0] pend, g;
    @(posedge clk);
    #1;
    sample_en = s; {req_tmr1, req_tmr0, req_usb} = rq; reg_wr = wr;
    reg_wdata = wd; reti = rt; stack_full = full; halted = hl;
    pend = m[6:4] & m[3:1];
    e.tag = tag;
    e.rd  = {1'b0, m};
    e.a   = s && m[0] && !full && (|pend);
    g     = pend[0] ? 3'b001 : pend[1] ? 3'b010 : pend[2] ? 3'b100 : 3'b000;
    e.v   = pend[0] ? 12'h004 : pend[1] ? 12'h008 : 12'h00C;
    e.w   = hl && (|(m[6:4] & ~(mhd ? mb : m[6:4])));
    q.push_back(e);
    if (hl && !mhd) mb = m[6:4];
    mhd = hl;
    if (wr) m = wd[6:0];
    if (rt) m[0] = 1'b1;
    if (e.a) begin
      m[0]   = 1'b0;
      m[6:4] = m[6:4] & ~g;
    end
    m[6:4] = m[6:4] | rq;
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (reg_rdata !== e.rd || ack !== e.a || wake !== e.w || (e.a && ack_vec !== e.v)) begin
        n_fail++;
        $display("FAIL %s: rd=%h ack=%b vec=%h wake=%b expected rd=%h ack=%b vec=%h wake=%b",
                 e.tag, reg_rdata, ack, ack_vec, wake, e.rd, e.a, e.v, e.w);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (reg_rdata !== 8'h00 || ack !== 1'b0 || wake !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: rd=%h ack=%b wake=%b expected rd=00 ack=0 wake=0",
               reg_rdata, ack, wake);
    end
    rst_n = 1'b1;
    //         s  rq     wr wd     rt full hl
    cyc(0, 3'b000, 0, 8'h00, 0, 0, 0, "R1 idle after reset");
    cyc(0, 3'b000, 1, 8'hFE, 0, 0, 0, "R1 write all");
    cyc(0, 3'b000, 0, 8'h00, 0, 0, 0, "R1 readback bit7 zero");
    cyc(0, 3'b000, 1, 8'h0E, 0, 0, 0, "R2 software clear");
    cyc(0, 3'b001, 0, 8'h00, 0, 0, 0, "R2 usb request");
    cyc(0, 3'b000, 0, 8'h00, 0, 0, 0, "R2 flag set");
    cyc(1, 3'b000, 0, 8'h00, 0, 0, 0, "R3 global off no ack");
    cyc(0, 3'b000, 1, 8'h1F, 0, 0, 0, "R3 set global enable");
    cyc(1, 3'b000, 0, 8'h00, 0, 1, 0, "R6 stack full withheld");
    cyc(0, 3'b000, 0, 8'h00, 0, 1, 0, "R6 flag kept");
    cyc(1, 3'b000, 0, 8'h00, 0, 0, 0, "R6 serviced after pop");
    cyc(0, 3'b000, 0, 8'h00, 0, 0, 0, "R5 flag and global cleared");
    cyc(0, 3'b000, 0, 8'h00, 1, 0, 0, "R7 reti");
    cyc(0, 3'b000, 0, 8'h00, 0, 0, 0, "R7 global restored");
    cyc(0, 3'b111, 0, 8'h00, 0, 0, 0, "R4 three requests");
    cyc(1, 3'b000, 0, 8'h00, 0, 0, 0, "R4 usb first vector 004");
    cyc(0, 3'b000, 0, 8'h00, 1, 0, 0, "R7 return");
    cyc(1, 3'b000, 0, 8'h00, 0, 0, 0, "R4 timer0 next vector 008");
    cyc(1, 3'b000, 0, 8'h00, 0, 0, 0, "R8 no nesting while global off");
    cyc(0, 3'b000, 1, 8'h4F, 0, 0, 0, "R8 software re-enable");
    cyc(1, 3'b000, 0, 8'h00, 0, 0, 0, "R8 nested timer1 vector 00C");
    cyc(0, 3'b010, 1, 8'h0F, 0, 0, 0, "R3 enable and timer0 request");
    cyc(0, 3'b000, 0, 8'h00, 0, 0, 0, "R3 no strobe no ack");
    cyc(0, 3'b000, 1, 8'h2B, 0, 0, 0, "R3 disable timer0");
    cyc(1, 3'b000, 0, 8'h00, 0, 0, 0, "R3 disabled source ignored");
    cyc(0, 3'b010, 1, 8'h0B, 0, 0, 0, "R2 hardware beats software clear");
    cyc(0, 3'b000, 1, 8'h2F, 0, 0, 0, "R2 flag survived");
    cyc(1, 3'b000, 1, 8'h6F, 0, 0, 0, "R5 ack over write");
    cyc(0, 3'b000, 0, 8'h00, 0, 0, 0, "R5 global and timer0 cleared");
    cyc(0, 3'b000, 1, 8'h10, 0, 0, 0, "R9 preset usb flag");
    cyc(0, 3'b000, 0, 8'h00, 0, 0, 1, "R9 halt entry");
    cyc(0, 3'b000, 0, 8'h00, 0, 0, 1, "R9 preset flag no wake");
    cyc(0, 3'b100, 0, 8'h00, 0, 0, 1, "R9 new request while halted");
    cyc(0, 3'b000, 0, 8'h00, 0, 0, 1, "R9 wake raised");
    cyc(0, 3'b000, 0, 8'h00, 0, 0, 0, "R9 not halted no wake");
    cyc(0, 3'b000, 0, 8'h00, 0, 0, 0, "R1 final state");
    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule